// File: doc/BRIEF.md
# Logic analyzer command decoder

This block sits behind a serial byte receiver and turns the host's logic analyzer command stream into configuration registers and control strobes for a capture engine. Every received byte arrives as a one-cycle valid strobe with its data byte. A byte whose top bit is clear is a short command and is acted on at once. A byte whose top bit is set opens a long command, and the next four bytes form its 32-bit argument.

The argument is assembled least-significant byte first. The target register is written only after the fourth argument byte has arrived. Short commands produce a one-cycle reset strobe (0x00) or arm strobe (0x01). There is no explicit frame resynchronisation. The host recovers a lost frame position by sending a run of zero bytes: zeros inside a pending frame fill its argument, and the zeros that follow act as reset commands.

Top module: `la_cmd_decoder`

## Requirements
- R1: After reset all register outputs (trigger mask, trigger value, trigger config, divider, flags, read count, delay count) are zero, and neither strobe is high.
- R2: A received byte 0x00 outside a long frame raises `reset_pulse` for exactly one cycle. The strobe is high in the second cycle after the byte is accepted.
- R3: A received byte 0x01 outside a long frame raises `arm_pulse` for exactly one cycle, with the same latency as R2.
- R4: Any other byte with bit 7 clear, received outside a long frame, is ignored. It produces no strobe and changes no register.
- R5: A byte with bit 7 set starts a long frame, and the following four accepted bytes form its argument. The first of these bytes lands in argument bits 7:0 and the last in bits 31:24. No register changes before the fourth argument byte. The register holds its new value from the second cycle after that byte.
- R6: Opcode 0xC0 loads the trigger mask, 0xC1 the trigger value, 0xC2 the trigger config, 0x80 the sample clock divider and 0x82 the flags, each with the full 32-bit argument.
- R7: Opcode 0x81 loads the read count from argument bits 31:16 and the delay count from argument bits 15:0.
- R8: A long opcode not named in R6 or R7 still consumes four argument bytes, but changes no register and raises no strobe.
- R9: Bytes inside a long frame are always argument data: a 0x00 or 0x01 there raises no strobe. Five consecutive zero bytes therefore end any partial frame, and each zero left over after that frame completes gives one reset strobe.
- R10: While `rx_valid` is low, the input byte has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| rx_byte | input | 8 | Received byte |
| reset_pulse | output | 1 | One-cycle reset command strobe |
| arm_pulse | output | 1 | One-cycle arm command strobe |
| trig_mask | output | 32 | Trigger mask register |
| trig_value | output | 32 | Trigger value register |
| trig_cfg | output | 32 | Trigger config register |
| clk_div | output | 32 | Sample clock divider register |
| read_count | output | 16 | Read count register |
| delay_count | output | 16 | Delay count register |
| flags | output | 32 | Flags register |

## Verification
Directed frames cover the following cases:
- Distinct bytes at each argument position. This separates least-first assembly from reversed or shifted assembly.
- A frame stopped after three bytes. This shows whether a register is written early.
- The 0x81 split, checked against the upper and lower argument halves.
- An unknown long opcode. It must still use up four bytes without changing any register.
- A partial frame followed by five zeros. This tells argument data apart from reset commands and fixes how many reset strobes the run must produce.

Seeded random frames then mix all opcodes with random arguments, stray short bytes and idle gaps. A bench model predicts every register value and strobe count.

// File: rtl/la_cmd_pkg.sv
package la_cmd_pkg;
    localparam int BYTE_W    = 8;
    localparam int ARG_BYTES = 4;
    localparam int ARG_W     = BYTE_W * ARG_BYTES;
    localparam int HALF_W    = ARG_W / 2;
    localparam int CNT_W     = $clog2(ARG_BYTES);

    localparam logic [BYTE_W-1:0] OP_RESET = 8'h00;
    localparam logic [BYTE_W-1:0] OP_ARM   = 8'h01;
    localparam logic [BYTE_W-1:0] OP_MASK  = 8'hC0;
    localparam logic [BYTE_W-1:0] OP_VALUE = 8'hC1;
    localparam logic [BYTE_W-1:0] OP_CFG   = 8'hC2;
    localparam logic [BYTE_W-1:0] OP_DIV   = 8'h80;
    localparam logic [BYTE_W-1:0] OP_COUNT = 8'h81;
    localparam logic [BYTE_W-1:0] OP_FLAGS = 8'h82;

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] op;
        logic [ARG_W-1:0]  word;
        logic              short_v;
        logic [BYTE_W-1:0] short_op;
        logic              long_v;
    } framer_st_t;

    typedef struct packed {
        logic [ARG_W-1:0]  mask;
        logic [ARG_W-1:0]  value;
        logic [ARG_W-1:0]  cfg;
        logic [ARG_W-1:0]  div;
        logic [ARG_W-1:0]  flags;
        logic [HALF_W-1:0] rd;
        logic [HALF_W-1:0] dly;
        logic              rst_p;
        logic              arm_p;
    } regs_st_t;
endpackage

// File: rtl/la_cmd_framer.sv
module la_cmd_framer
    import la_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              short_valid,
    output logic [BYTE_W-1:0] short_op,
    output logic              long_valid,
    output logic [BYTE_W-1:0] long_op,
    output logic [ARG_W-1:0]  long_arg
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ARG_BYTES - 1);

    framer_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.short_v = 1'b0;
        st_d.long_v  = 1'b0;
        if (rx_valid) begin
            if (st_q.busy) begin
                st_d.word = {rx_byte, st_q.word[ARG_W-1:BYTE_W]};
                if (st_q.cnt == LAST) begin
                    st_d.busy   = 1'b0;
                    st_d.cnt    = '0;
                    st_d.long_v = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else if (rx_byte[BYTE_W-1]) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                st_d.op   = rx_byte;
            end else begin
                st_d.short_v  = 1'b1;
                st_d.short_op = rx_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign short_valid = st_q.short_v;
    assign short_op    = st_q.short_op;
    assign long_valid  = st_q.long_v;
    assign long_op     = st_q.op;
    assign long_arg    = st_q.word;

    // R9: no short command may come out of a byte taken inside a frame
    assert_no_short_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && rx_valid) |=> !short_valid);
    // R5: a frame completes only on an accepted fourth argument byte
    assert_frame_on_fourth_R5: assert property (@(posedge clk) disable iff (!rst_n)
        long_valid |-> ($past(rx_valid) && $past(st_q.busy) && $past(st_q.cnt) == LAST));
    // R10: idle input leaves the frame position untouched
    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> ($stable(st_q.busy) && $stable(st_q.cnt)));
endmodule

// File: rtl/la_cmd_regs.sv
module la_cmd_regs
    import la_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              short_valid,
    input  logic [BYTE_W-1:0] short_op,
    input  logic              long_valid,
    input  logic [BYTE_W-1:0] long_op,
    input  logic [ARG_W-1:0]  long_arg,
    output regs_st_t          regs
);
    regs_st_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.rst_p = short_valid && (short_op == OP_RESET);
        r_d.arm_p = short_valid && (short_op == OP_ARM);
        if (long_valid) begin
            case (long_op)
                OP_MASK:  r_d.mask  = long_arg;
                OP_VALUE: r_d.value = long_arg;
                OP_CFG:   r_d.cfg   = long_arg;
                OP_DIV:   r_d.div   = long_arg;
                OP_FLAGS: r_d.flags = long_arg;
                OP_COUNT: begin
                    r_d.rd  = long_arg[ARG_W-1:HALF_W];
                    r_d.dly = long_arg[HALF_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign regs = r_q;

    // R2: the two strobes never coincide
    assert_pulse_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.rst_p && r_q.arm_p));
    // R5: configuration holds unless a frame just completed
    assert_regs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !long_valid |=> ($stable(r_q.mask) && $stable(r_q.value) && $stable(r_q.cfg)
                         && $stable(r_q.div) && $stable(r_q.flags)
                         && $stable(r_q.rd) && $stable(r_q.dly)));
    // R3: an arm strobe follows a short command one cycle earlier
    assert_arm_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.arm_p |-> $past(short_valid));
endmodule

// File: rtl/la_cmd_decoder.sv
module la_cmd_decoder
    import la_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output logic        reset_pulse,
    output logic        arm_pulse,
    output logic [31:0] trig_mask,
    output logic [31:0] trig_value,
    output logic [31:0] trig_cfg,
    output logic [31:0] clk_div,
    output logic [15:0] read_count,
    output logic [15:0] delay_count,
    output logic [31:0] flags
);
    logic              short_valid, long_valid;
    logic [BYTE_W-1:0] short_op, long_op;
    logic [ARG_W-1:0]  long_arg;
    regs_st_t          regs;

    la_cmd_framer u_framer (
        .clk, .rst_n, .rx_valid, .rx_byte,
        .short_valid, .short_op, .long_valid, .long_op, .long_arg
    );

    la_cmd_regs u_regs (
        .clk, .rst_n, .short_valid, .short_op,
        .long_valid, .long_op, .long_arg, .regs
    );

    assign reset_pulse = regs.rst_p;
    assign arm_pulse   = regs.arm_p;
    assign trig_mask   = regs.mask;
    assign trig_value  = regs.value;
    assign trig_cfg    = regs.cfg;
    assign clk_div     = regs.div;
    assign read_count  = regs.rd;
    assign delay_count = regs.dly;
    assign flags       = regs.flags;
endmodule

// File: tb/la_cmd_decoder_tb.sv
module la_cmd_decoder_tb;
    logic clk = 1'b0, rst_n = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic reset_pulse, arm_pulse;
    logic [31:0] trig_mask, trig_value, trig_cfg, clk_div, flags;
    logic [15:0] read_count, delay_count;

    always #5 clk = ~clk;

    la_cmd_decoder u_dut (.*);

    int n_checks = 0, n_fail = 0;
    int n_rst = 0, n_arm = 0, exp_rst = 0, exp_arm = 0;
    bit done = 0;

    // model
    logic [31:0] m_mask, m_value, m_cfg, m_div, m_flags;
    logic [15:0] m_rd, m_dly;
    bit m_busy; int m_cnt; logic [7:0] m_op; logic [31:0] m_word;

    always @(negedge clk) if (rst_n) begin
        if (reset_pulse) n_rst++;
        if (arm_pulse) n_arm++;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pack_arg(logic [7:0] b0, logic [7:0] b1,
                                              logic [7:0] b2, logic [7:0] b3);
        return {b3, b2, b1, b0};
    endfunction

    task automatic model_byte(logic [7:0] b);
        if (m_busy) begin
            m_word = {b, m_word[31:8]};
            m_cnt++;
            if (m_cnt == 4) begin
                m_busy = 0;
                case (m_op)
                    8'hC0: m_mask  = m_word;
                    8'hC1: m_value = m_word;
                    8'hC2: m_cfg   = m_word;
                    8'h80: m_div   = m_word;
                    8'h82: m_flags = m_word;
                    8'h81: begin m_rd = m_word[31:16]; m_dly = m_word[15:0]; end
                    default: ;
                endcase
            end
        end else if (b[7]) begin
            m_busy = 1; m_cnt = 0; m_op = b;
        end else if (b == 8'h00) exp_rst++;
        else if (b == 8'h01) exp_arm++;
    endtask

    task automatic send(logic [7:0] b, int gap);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0; rx_byte = $urandom;
        model_byte(b);
        repeat (gap) @(negedge clk);
    endtask

    task automatic settle(); repeat (3) @(negedge clk); endtask

    task automatic check_all(string req);
        check(req, trig_mask, m_mask);
        check(req, trig_value, m_value);
        check(req, trig_cfg, m_cfg);
        check(req, clk_div, m_div);
        check(req, flags, m_flags);
        check(req, {read_count, delay_count}, {m_rd, m_dly});
        check(req, n_rst, exp_rst);
        check(req, n_arm, exp_arm);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] ops [8] = '{8'hC0, 8'hC1, 8'hC2, 8'h80, 8'h81, 8'h82, 8'h83, 8'hFF};
        void'($urandom(32'h1234));
        m_mask = 0; m_value = 0; m_cfg = 0; m_div = 0; m_flags = 0;
        m_rd = 0; m_dly = 0; m_busy = 0; m_cnt = 0; m_op = 0; m_word = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_all("R1");
        check("R1 strobes", {30'd0, reset_pulse, arm_pulse}, 32'd0);

        // R2 single reset byte; sample exact cycle
        @(negedge clk); rx_valid = 1; rx_byte = 8'h00;
        @(negedge clk); rx_valid = 0; model_byte(8'h00);
        check("R2 not yet", reset_pulse, 0);
        @(negedge clk); check("R2 pulse", reset_pulse, 1);
        @(negedge clk); check("R2 one cycle", reset_pulse, 0);
        // R3 arm
        send(8'h01, 0); settle(); check("R3", n_arm, exp_arm);
        // R4 ignored shorts
        send(8'h05, 0); send(8'h7F, 0); send(8'h02, 0); settle(); check_all("R4");
        // R10 rx_byte wiggles with valid low
        @(negedge clk); rx_byte = 8'hC0; repeat (2) @(negedge clk); rx_byte = 8'h00;
        settle();
        send(8'h01, 0); settle(); check_all("R10");
        // R5 partial frame then completion
        send(8'hC0, 0); send(8'h11, 0); send(8'h22, 1); send(8'h33, 0); settle();
        check("R5 early", trig_mask, 32'd0);
        @(negedge clk); rx_valid = 1; rx_byte = 8'h44;
        @(negedge clk); rx_valid = 0; model_byte(8'h44);
        check("R5 latency", trig_mask, 32'd0);
        @(negedge clk); check("R5 order", trig_mask, 32'h44332211);
        // R7 split
        send(8'h81, 0); send(8'hFF, 0); send(8'h01, 0); send(8'hFF, 0); send(8'h01, 0);
        settle();
        check("R7 read", read_count, 16'h01FF); check("R7 delay", delay_count, 16'h01FF);
        // R6 divider zero, value/cfg/flags
        send(8'h80, 0); repeat (4) send(8'h00, 0);
        send(8'hC1, 0); send(8'hAA, 0); send(8'hBB, 0); send(8'hCC, 0); send(8'hDD, 0);
        send(8'h82, 0); send(8'h01, 0); send(8'h00, 0); send(8'h00, 0); send(8'h80, 0);
        settle();
        check("R6 value", trig_value, 32'hDDCCBBAA);
        check("R6 flags", flags, 32'h80000001);
        check_all("R6");
        // R8 unknown long
        send(8'h83, 0); send(8'h12, 0); send(8'h34, 0); send(8'h56, 0); send(8'h78, 0);
        settle(); check_all("R8");
        // R9 partial frame then five zeros
        send(8'hC2, 0); send(8'h5A, 0); send(8'h01, 0);
        repeat (5) send(8'h00, 0);
        settle();
        check("R9 cfg", trig_cfg, pack_arg(8'h5A, 8'h01, 8'h00, 8'h00));
        check_all("R9");

        // random mix
        for (int i = 0; i < 300; i++) begin
            int k = $urandom_range(0, 9);
            if (k < 8) begin
                send(ops[k], $urandom_range(0, 2));
                for (int j = 0; j < 4; j++) send(8'($urandom), $urandom_range(0, 2));
            end else begin
                send(8'($urandom_range(0, 8)), $urandom_range(0, 2));
            end
            if (i % 20 == 19) begin settle(); check_all("R6 random"); end
        end
        settle();
        check_all("R5 random");
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule